// File: doc/BRIEF.md
# PHY Control-Port Handshake Master

This block runs single register operations on a PHY's internal control port. Each operation steps through strobe lines that are paired with one shared acknowledge line. The caller pulses a start input with an opcode and a 16-bit operand. The block then takes one of three actions:

- **Address:** latches the operand as the PHY register address.
- **Write:** hands the operand to the PHY as data and commits it.
- **Read:** returns the PHY's output word.

All outputs to the PHY are packed into one control word. The low 16 bits carry the data-in value and the four bits above them carry the strobes.

Every strobe step is a complete four-phase exchange. The strobe is raised and the block waits until the acknowledge is seen high. The strobe is then lowered and the block waits until the acknowledge is seen low. The acknowledge passes through a synchroniser. It is sampled once per poll interval, up to a fixed number of times. A step that never sees the expected level ends the operation at once with an error. A write whose data has bit 0 set puts the PHY into reset, and a PHY in reset cannot answer. For that write the block raises the write strobe and finishes without waiting.

Top module: `phy_cr_master`

## Requirements
- R1: The control word `phy_ctrl` carries data-in in bits 15:0, the capture-address strobe in bit 16, the capture-data strobe in bit 17, the write strobe in bit 18 and the read strobe in bit 19. The opcode `cmd_op` takes these values: 0 = address, 1 = write, 2 = read, 3 = reserved.
- R2: Each strobe step follows the same pattern. The strobe is driven high until the synchronised acknowledge is sampled high, then driven low until the acknowledge is sampled low. At most one strobe is high at any time.
- R3: An address operation puts the operand on data-in and then performs one capture-address handshake. Data-in stays unchanged for the whole operation.
- R4: A write operation with operand bit 0 clear does the following, in this order:
  1. puts the operand on data-in;
  2. performs a full capture-data handshake;
  3. performs a full write-strobe handshake.
- R5: A write operation with operand bit 0 set first performs the capture-data handshake. It then raises the write strobe and completes without error and without waiting for the acknowledge. The write strobe stays high until the next accepted command.
- R6: A read operation raises the read strobe. When the acknowledge is seen high, the block captures `phy_data_out` into `rd_data`. It then completes the falling half of the handshake. Data-in is left unchanged. `rd_data` holds its value until the next read.
- R7: The acknowledge is sampled once every POLL_CYCLES cycles, up to POLL_LIMIT samples per handshake half. If the acknowledge is slow but arrives within that window, the operation succeeds. If the first step never sees the acknowledge, `busy` stays high for exactly POLL_LIMIT*POLL_CYCLES+1 cycles and the operation ends with `err` set.
- R8: A handshake timeout aborts the operation. None of the remaining strobes is driven, and the strobes keep their levels until the next accepted command.
- R9: A start pulse while `busy` is high is ignored.
- R10: The reserved opcode produces a `done` pulse with `err` set in the cycle after start. It sets no `busy` and changes no control-word bit.
- R11: `done` is a one-cycle pulse with `busy` low. `err` is valid with `done` and is held until the next accepted start.
- R12: During and after reset, `phy_ctrl`, `busy`, `done`, `err` and `rd_data` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_start | input | 1 | Start pulse for one operation |
| cmd_op | input | 2 | Opcode: 0 address, 1 write, 2 read, 3 reserved |
| cmd_arg | input | 16 | Address or write data |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Last operation timed out or was reserved |
| rd_data | output | 16 | Data captured by the last read |
| phy_ctrl | output | 20 | Data-in and strobe word to the PHY |
| phy_ack | input | 1 | Asynchronous acknowledge from the PHY |
| phy_data_out | input | 16 | PHY output data |

## Verification
The bench builds the block with POLL_CYCLES = 4 and POLL_LIMIT = 10, which makes a full poll window 40 cycles long. With these values the exact busy length of a timed-out step (41 cycles) is cheap to check. The values also let the bench's PHY model answer after more than 20 cycles, so successful handshakes need many polls. Timeouts in the rising and in the falling half of a handshake are both reached in a short run.

// File: rtl/phy_cr_pkg.sv
package phy_cr_pkg;

  typedef enum logic [1:0] {
    OP_ADDR  = 2'd0,
    OP_WRITE = 2'd1,
    OP_READ  = 2'd2,
    OP_RSVD  = 2'd3
  } op_e;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_LAUNCH = 2'd1,
    ST_WAIT   = 2'd2
  } seq_e;

  localparam int NUM_STROBES = 4;
  localparam logic [1:0] SB_CAP_ADDR = 2'd0;
  localparam logic [1:0] SB_CAP_DATA = 2'd1;
  localparam logic [1:0] SB_WRITE    = 2'd2;
  localparam logic [1:0] SB_READ     = 2'd3;

endpackage

// File: rtl/phy_cr_sync.sv
module phy_cr_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q[i] <= 1'b0;
        else if (i == 0) chain_q[i] <= d;
        else chain_q[i] <= chain_q[(i > 0) ? i-1 : 0];
      end
    end
  endgenerate

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/phy_cr_poller.sv
module phy_cr_poller #(
  parameter int POLL_CYCLES = 20000,
  parameter int POLL_LIMIT  = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic go,
  input  logic want_in,
  input  logic ack_s,
  output logic hit,
  output logic expired
);
  localparam int CW = $clog2(POLL_CYCLES + 1);
  localparam int TW = $clog2(POLL_LIMIT + 1);
  localparam logic [CW-1:0] RELOAD   = CW'(POLL_CYCLES - 1);
  localparam logic [TW-1:0] LAST_TRY = TW'(POLL_LIMIT - 1);

  logic          active_q, active_d;
  logic          want_q, want_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [TW-1:0] tries_q, tries_d;
  logic          tick, match;

  always_comb begin
    tick    = active_q && (cnt_q == '0);
    match   = (ack_s == want_q);
    hit     = tick && match;
    expired = tick && !match && (tries_q == LAST_TRY);
  end

  always_comb begin
    active_d = active_q;
    want_d   = want_q;
    cnt_d    = cnt_q;
    tries_d  = tries_q;
    if (go) begin
      active_d = 1'b1;
      want_d   = want_in;
      cnt_d    = RELOAD;
      tries_d  = '0;
    end else if (tick) begin
      if (hit || expired) begin
        active_d = 1'b0;
      end else begin
        cnt_d   = RELOAD;
        tries_d = tries_q + 1'b1;
      end
    end else if (active_q) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      want_q   <= 1'b0;
      cnt_q    <= '0;
      tries_q  <= '0;
    end else begin
      active_q <= active_d;
      want_q   <= want_d;
      cnt_q    <= cnt_d;
      tries_q  <= tries_d;
    end
  end
endmodule

// File: rtl/phy_cr_step_dec.sv
module phy_cr_step_dec
  import phy_cr_pkg::*;
(
  input  op_e        op,
  input  logic [1:0] step,
  output logic [1:0] sel,
  output logic       lvl,
  output logic       last
);
  always_comb begin
    lvl = ~step[0];
    unique case (op)
      OP_ADDR: begin
        sel  = SB_CAP_ADDR;
        last = (step == 2'd1);
      end
      OP_WRITE: begin
        sel  = step[1] ? SB_WRITE : SB_CAP_DATA;
        last = (step == 2'd3);
      end
      OP_READ: begin
        sel  = SB_READ;
        last = (step == 2'd1);
      end
      default: begin
        sel  = SB_CAP_ADDR;
        lvl  = 1'b0;
        last = 1'b1;
      end
    endcase
  end
endmodule

// File: rtl/phy_cr_master.sv
module phy_cr_master
  import phy_cr_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int POLL_CYCLES = 20000,
  parameter int POLL_LIMIT  = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          cmd_start,
  input  logic [1:0]                    cmd_op,
  input  logic [DATA_W-1:0]             cmd_arg,
  output logic                          busy,
  output logic                          done,
  output logic                          err,
  output logic [DATA_W-1:0]             rd_data,
  output logic [DATA_W+NUM_STROBES-1:0] phy_ctrl,
  input  logic                          phy_ack,
  input  logic [DATA_W-1:0]             phy_data_out
);
  localparam int RESET_BIT = 0;

  seq_e                   state_q, state_d;
  op_e                    op_q, op_d;
  logic [1:0]             step_q, step_d;
  logic [DATA_W-1:0]      din_q, din_d;
  logic [NUM_STROBES-1:0] strb_q, strb_d;
  logic [DATA_W-1:0]      rd_q, rd_d;
  logic                   done_q, done_d;
  logic                   err_q, err_d;

  logic       ack_s;
  logic       go, hit, expired;
  logic [1:0] sel;
  logic       lvl, last;
  logic       reset_cut;

  phy_cr_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (phy_ack),
    .q     (ack_s)
  );

  phy_cr_step_dec u_dec (
    .op   (op_q),
    .step (step_q),
    .sel  (sel),
    .lvl  (lvl),
    .last (last)
  );

  phy_cr_poller #(
    .POLL_CYCLES (POLL_CYCLES),
    .POLL_LIMIT  (POLL_LIMIT)
  ) u_poll (
    .clk     (clk),
    .rst_n   (rst_n),
    .go      (go),
    .want_in (lvl),
    .ack_s   (ack_s),
    .hit     (hit),
    .expired (expired)
  );

  assign reset_cut = (op_q == OP_WRITE) && (step_q == 2'd1) && din_q[RESET_BIT];

  always_comb begin
    state_d = state_q;
    op_d    = op_q;
    step_d  = step_q;
    din_d   = din_q;
    strb_d  = strb_q;
    rd_d    = rd_q;
    err_d   = err_q;
    done_d  = 1'b0;
    go      = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (cmd_start) begin
          if (op_e'(cmd_op) == OP_RSVD) begin
            done_d = 1'b1;
            err_d  = 1'b1;
          end else begin
            err_d   = 1'b0;
            strb_d  = '0;
            op_d    = op_e'(cmd_op);
            step_d  = 2'd0;
            if (op_e'(cmd_op) != OP_READ) din_d = cmd_arg;
            state_d = ST_LAUNCH;
          end
        end
      end
      ST_LAUNCH: begin
        strb_d[sel] = lvl;
        go          = 1'b1;
        state_d     = ST_WAIT;
      end
      ST_WAIT: begin
        if (hit) begin
          if ((op_q == OP_READ) && (step_q == 2'd0)) rd_d = phy_data_out;
          if (last) begin
            done_d  = 1'b1;
            state_d = ST_IDLE;
          end else if (reset_cut) begin
            strb_d[SB_WRITE] = 1'b1;
            done_d           = 1'b1;
            state_d          = ST_IDLE;
          end else begin
            step_d  = step_q + 1'b1;
            state_d = ST_LAUNCH;
          end
        end else if (expired) begin
          err_d   = 1'b1;
          done_d  = 1'b1;
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      op_q    <= OP_ADDR;
      step_q  <= '0;
      din_q   <= '0;
      strb_q  <= '0;
      rd_q    <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      op_q    <= op_d;
      step_q  <= step_d;
      din_q   <= din_d;
      strb_q  <= strb_d;
      rd_q    <= rd_d;
      done_q  <= done_d;
      err_q   <= err_d;
    end
  end

  assign busy     = (state_q != ST_IDLE);
  assign done     = done_q;
  assign err      = err_q;
  assign rd_data  = rd_q;
  assign phy_ctrl = {strb_q, din_q};
endmodule

// File: rtl/phy_cr_master_chk.sv
module phy_cr_master_chk #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              done,
  input logic [DATA_W+3:0] phy_ctrl
);
  logic [3:0]        strb;
  logic [DATA_W-1:0] din;
  assign strb = phy_ctrl[DATA_W+3:DATA_W];
  assign din  = phy_ctrl[DATA_W-1:0];

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(strb)); // R2
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R11
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R11
  AST_DIN_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(din)); // R3
  AST_IDLE_STROBES: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !$past(busy)) |-> $stable(strb)); // R8
endmodule

bind phy_cr_master phy_cr_master_chk #(.DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .busy     (busy),
  .done     (done),
  .phy_ctrl (phy_ctrl)
);

// File: tb/phy_cr_master_tb_top.sv
module phy_cr_master_tb_top;
  localparam int PC = 4;
  localparam int PL = 10;

  logic        clk, rst_n;
  logic        start;
  logic [1:0]  cop;
  logic [15:0] carg;
  logic        busy, done, err;
  logic [15:0] rd_data;
  logic [19:0] ctrl;
  logic        ack_m;
  logic [15:0] dout;

  phy_cr_master #(.DATA_W(16), .POLL_CYCLES(PC), .POLL_LIMIT(PL), .SYNC_STAGES(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_start(start), .cmd_op(cop), .cmd_arg(carg),
    .busy(busy), .done(done), .err(err), .rd_data(rd_data),
    .phy_ctrl(ctrl), .phy_ack(ack_m), .phy_data_out(dout)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // PHY model: mode 0 normal, 1 slow, 2 mute, 3 ack stuck high
  logic [1:0]  mode;
  logic [3:0]  strb, strb_p;
  logic [15:0] mem [16];
  logic [15:0] addr_m, cd_m;
  logic        stuck_q, tgt;
  int          dly_c;
  assign strb = ctrl[19:16];
  assign dout = mem[addr_m[3:0]];

  always_comb begin
    case (mode)
      2'd2:    tgt = 1'b0;
      2'd3:    tgt = stuck_q | (|strb);
      default: tgt = (|strb) && !(strb[2] && ctrl[0]);
    endcase
  end

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_m <= 1'b0; dly_c <= 0; stuck_q <= 1'b0; strb_p <= '0;
      addr_m <= '0; cd_m <= '0;
      for (int i = 0; i < 16; i++) mem[i] <= 16'hA000 + 16'(i);
    end else begin
      strb_p <= strb;
      if (tgt != ack_m) begin
        if (dly_c >= ((mode == 2'd1) ? 22 : 2)) begin ack_m <= tgt; dly_c <= 0; end
        else dly_c <= dly_c + 1;
      end else dly_c <= 0;
      if (mode != 2'd3) stuck_q <= 1'b0; else if (ack_m) stuck_q <= 1'b1;
      if (strb[0] && !strb_p[0]) addr_m <= ctrl[15:0];
      if (strb[1] && !strb_p[1]) cd_m <= ctrl[15:0];
      if (strb[2] && !strb_p[2]) mem[addr_m[3:0]] <= cd_m;
    end
  end

  // strobe change history, newest nibble lowest
  logic [31:0] hist;
  logic [3:0]  hprev;
  int          evt_cnt;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin hist <= '0; hprev <= '0; evt_cnt <= 0; end
    else if (strb != hprev) begin
      hist <= {hist[27:0], strb}; hprev <= strb; evt_cnt <= evt_cnt + 1;
    end
  end

  int n_cmp = 0, n_bad = 0;
  int busy_n, got_n, exp_extra;
  logic [31:0] got_h;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] nmask(input int n);
    return (n >= 8) ? 32'hFFFF_FFFF : ((32'h1 << (4*n)) - 1);
  endfunction

  task automatic run_cmd(input logic [1:0] op, input logic [15:0] arg);
    int ev0, g;
    exp_extra = (strb != 4'h0 && op != 2'd3) ? 1 : 0;
    ev0 = evt_cnt;
    @(negedge clk); start = 1'b1; cop = op; carg = arg;
    @(negedge clk); start = 1'b0;
    busy_n = 0; g = 0;
    while (!done && g < 5000) begin
      if (busy) busy_n++;
      @(negedge clk); g++;
    end
    @(negedge clk); @(negedge clk);
    got_n = evt_cnt - ev0;
    got_h = hist & nmask(got_n);
  endtask

  typedef struct packed {
    logic [1:0]  mode;
    logic [1:0]  op;
    logic [15:0] arg;
    logic        xerr;
    logic        chk_rd;
    logic [15:0] xrd;
    logic [15:0] xhist;
    logic [3:0]  xn;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VEC [NV] = '{
    '{2'd0, 2'd0, 16'h0003, 1'b0, 1'b0, 16'h0000, 16'h0010, 4'd2}, // R3
    '{2'd0, 2'd1, 16'h1234, 1'b0, 1'b0, 16'h0000, 16'h2040, 4'd4}, // R4
    '{2'd0, 2'd2, 16'h0000, 1'b0, 1'b1, 16'h1234, 16'h0080, 4'd2}, // R6
    '{2'd1, 2'd0, 16'h0005, 1'b0, 1'b0, 16'h0000, 16'h0010, 4'd2}, // R7 slow
    '{2'd1, 2'd2, 16'h0000, 1'b0, 1'b1, 16'hA005, 16'h0080, 4'd2}, // R7 slow
    '{2'd1, 2'd1, 16'hBEEE, 1'b0, 1'b0, 16'h0000, 16'h2040, 4'd4}, // R4 slow
    '{2'd0, 2'd2, 16'h0000, 1'b0, 1'b1, 16'hBEEE, 16'h0080, 4'd2}, // R6
    '{2'd3, 2'd0, 16'h0007, 1'b1, 1'b0, 16'h0000, 16'h0010, 4'd2}, // R8 fall timeout
    '{2'd3, 2'd1, 16'h4444, 1'b1, 1'b0, 16'h0000, 16'h0020, 4'd2}, // R8 abort
    '{2'd0, 2'd2, 16'h0000, 1'b0, 1'b1, 16'hA007, 16'h0080, 4'd2}, // R8 no write
    '{2'd2, 2'd0, 16'h0002, 1'b1, 1'b0, 16'h0000, 16'h0001, 4'd1}, // R7 mute
    '{2'd0, 2'd2, 16'h0000, 1'b0, 1'b1, 16'hA002, 16'h0080, 4'd2}  // R6
  };

  initial begin
    for (int c = 0; c < 100000; c++) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=done", n_cmp);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [15:0] din_prev;
    rst_n = 1'b0; start = 1'b0; cop = '0; carg = '0; mode = 2'd0;
    repeat (4) @(negedge clk);
    // R12 reset state
    chk("R12 ctrl", 32'(ctrl), 32'h0);
    chk("R12 busy/done/err", {29'h0, busy, done, err}, 32'h0);
    chk("R12 rd_data", 32'(rd_data), 32'h0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      mode = VEC[v].mode;
      repeat (12) @(negedge clk);
      din_prev = ctrl[15:0];
      run_cmd(VEC[v].op, VEC[v].arg);
      chk($sformatf("R7/R8 err vec%0d", v), 32'(err), 32'(VEC[v].xerr));
      chk($sformatf("R2 strobe order vec%0d", v), got_h, 32'(VEC[v].xhist));
      chk($sformatf("R2 strobe events vec%0d", v), 32'(got_n), 32'(VEC[v].xn) + 32'(exp_extra));
      if (VEC[v].chk_rd) begin
        chk($sformatf("R6 rd_data vec%0d", v), 32'(rd_data), 32'(VEC[v].xrd));
        chk($sformatf("R6 data-in kept vec%0d", v), 32'(ctrl[15:0]), 32'(din_prev));
      end else if (VEC[v].op == 2'd0) begin
        chk($sformatf("R1 R3 data-in vec%0d", v), 32'(ctrl[15:0]), 32'(VEC[v].arg));
      end
    end

    // R11 err held after the last timeout-free op cleared it, then set by timeout
    mode = 2'd2; repeat (12) @(negedge clk);
    run_cmd(2'd0, 16'h0001);
    chk("R7 timeout busy length", 32'(busy_n), 32'(PL*PC+1));
    repeat (5) @(negedge clk);
    chk("R11 err held", 32'(err), 32'h1);
    chk("R8 strobe held after abort", 32'(strb), 32'h1);

    // R5 reset write
    mode = 2'd0; repeat (12) @(negedge clk);
    run_cmd(2'd0, 16'h000C);
    chk("R11 err cleared", 32'(err), 32'h0);
    run_cmd(2'd1, 16'h0001);
    chk("R5 no error", 32'(err), 32'h0);
    chk("R5 order", got_h, 32'h204);
    repeat (8) @(negedge clk);
    chk("R5 write strobe held", 32'(ctrl[18]), 32'h1);
    run_cmd(2'd0, 16'h000D);
    chk("R5 cleared by next command", 32'(got_h), 32'h010);

    // R9 start ignored while busy
    repeat (6) @(negedge clk);
    @(negedge clk); start = 1'b1; cop = 2'd0; carg = 16'h0009;
    @(negedge clk); start = 1'b0;
    @(negedge clk); @(negedge clk);
    start = 1'b1; cop = 2'd1; carg = 16'h5555;
    @(negedge clk); start = 1'b0;
    while (!done) @(negedge clk);
    repeat (3) @(negedge clk);
    chk("R9 busy start ignored data-in", 32'(ctrl[15:0]), 32'h0009);
    chk("R9 idle after", 32'(busy), 32'h0);

    // R10 reserved opcode
    din_prev = ctrl[15:0];
    @(negedge clk); start = 1'b1; cop = 2'd3; carg = 16'hFFFF;
    @(negedge clk); start = 1'b0;
    chk("R10 done next cycle", {30'h0, done, busy}, 32'h2);
    chk("R10 err", 32'(err), 32'h1);
    @(negedge clk);
    chk("R11 done single pulse", 32'(done), 32'h0);
    chk("R10 ctrl unchanged", 32'(ctrl), {12'h0, din_prev});

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule